// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in seven packed-BCD registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. A fast sub-second strobe feeds an internal divider. Each time the divider completes a full second while the run enable is high, the seconds register advances and carries ripple upward through the calendar. Hours can be kept as a 24-hour count or as a 12-hour count with a PM flag. February gains a 29th day in every year divisible by four.

Software reaches the registers through a simple synchronous port. A write lands in the addressed register on the next clock edge. A write to the seconds register also restarts the divider, so a full second passes before the next carry, and the other fields can be loaded without a rollover in between. A read command with its start flag set captures all seven registers into a shadow copy. Later reads without the start flag return that copy, so a multi-byte read sees one consistent instant.

Top module: `rtc_bcd_core`

## Requirements
- R1: Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. A read of address 7 returns 00h, and a write to address 7 changes no register.
- R2: Writes are masked so that undefined bits stay 0. The masks are: seconds, minutes and hours 7Fh; weekday 07h; day of month 3Fh; month 1Fh; year FFh. For example, writing FFh to the weekday register reads back as 07h.
- R3: While rst is high, every register and rdata clear to 00h.
- R4: Seconds and minutes count in BCD from 00 to 59. When either one wraps to 00, it carries into the next field.
- R5: Hours bit 6 = 0 selects 24-hour mode, in which bits 5:0 count BCD 00 to 23. Wrapping from 23 back to 00 advances the day.
- R6: Hours bit 6 = 1 selects 12-hour mode. Bit 5 is PM (1) or AM (0), and bits 4:0 follow the sequence 12, 01, ..., 11. Going from 11 to 12 inverts bit 5. Only the step from 11 PM to 12 AM advances the day.
- R7: The weekday counts from 1 to 7, and a day step from 7 gives 1.
- R8: The day of month wraps to 01 after the last day of the month: 30 for April, June, September and November, 31 for the other months except February. The month goes from 12 to 01 and advances the year, and the year goes from 99 to 00.
- R9: February ends on day 29 when the BCD year value is a multiple of four, including 00. In other years it ends on day 28.
- R10: Time advances only while osc_en is 1. With osc_en at 0, sub_tick pulses have no effect.
- R11: The seconds register steps on every TICKS_PER_SEC-th sub_tick. A write to seconds restarts this count, and a sub_tick in the same cycle as that write does not step.
- R12: rdata is registered with one cycle of latency and holds its value when rd_en is low. A read with rd_start = 1 captures all registers and returns the current value. A read with rd_start = 0 returns the last captured value.
- R13: When a write and a seconds step happen in the same cycle, the written register takes the written value, and the other registers take their stepped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Run enable for timekeeping |
| sub_tick | input | 1 | One-cycle sub-second strobe |
| wr_en | input | 1 | Register write strobe |
| rd_start | input | 1 | Capture all registers into the shadow copy |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A software write and the carry chain of a completed second can land on the same clock edge. The bench provokes this by holding sub_tick high in the same cycle as a write. In one case it writes the minutes while the seconds wrap from 59, and expects the seconds at 00 with the written minutes kept and the carry dropped. In the other case it writes the seconds on the final divider tick, and expects the written value with no step, followed by a full-length second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 7;
  localparam int AW   = 3;

  typedef logic [7:0] bcd8_t;

  localparam logic [AW-1:0] A_SEC  = 3'd0;
  localparam logic [AW-1:0] A_MIN  = 3'd1;
  localparam logic [AW-1:0] A_HOUR = 3'd2;
  localparam logic [AW-1:0] A_DOW  = 3'd3;
  localparam logic [AW-1:0] A_DATE = 3'd4;
  localparam logic [AW-1:0] A_MON  = 3'd5;
  localparam logic [AW-1:0] A_YEAR = 3'd6;

  function automatic bcd8_t wr_mask(input logic [AW-1:0] a);
    case (a)
      A_SEC, A_MIN, A_HOUR: return 8'h7F;
      A_DOW:                return 8'h07;
      A_DATE:               return 8'h3F;
      A_MON:                return 8'h1F;
      A_YEAR:               return 8'hFF;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  // Year divisible by four, decided on the BCD digits directly.
  function automatic logic is_leap(input bcd8_t y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic bcd8_t last_day(input bcd8_t m, input bcd8_t y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign step_o  = en_i && tick_i && at_last && !restart_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt <= '0;
    else if (en_i && tick_i) cnt <= at_last ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [7:0]                wr_data_i,
  output logic [NREG-1:0][7:0]      live_o
);
  logic [NREG-1:0][7:0] nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;
  logic pm;
  logic [4:0] h12;
  bcd8_t h12_inc;

  always_comb begin
    nxt     = live_o;
    c_min   = 1'b0;
    c_hour  = 1'b0;
    c_day   = 1'b0;
    c_mon   = 1'b0;
    c_year  = 1'b0;
    pm      = live_o[A_HOUR][5];
    h12     = live_o[A_HOUR][4:0];
    h12_inc = bcd_inc({3'b000, h12});

    if (live_o[A_SEC] >= 8'h59) begin nxt[A_SEC] = 8'h00; c_min = 1'b1; end
    else nxt[A_SEC] = bcd_inc(live_o[A_SEC]);

    if (c_min) begin
      if (live_o[A_MIN] >= 8'h59) begin nxt[A_MIN] = 8'h00; c_hour = 1'b1; end
      else nxt[A_MIN] = bcd_inc(live_o[A_MIN]);
    end

    if (c_hour) begin
      if (!live_o[A_HOUR][6]) begin
        if (live_o[A_HOUR][5:0] >= 6'h23) begin nxt[A_HOUR] = 8'h00; c_day = 1'b1; end
        else nxt[A_HOUR] = bcd_inc(live_o[A_HOUR] & 8'h3F);
      end else begin
        if (h12 == 5'h11) begin
          nxt[A_HOUR] = {2'b01, ~pm, 5'h12};
          c_day       = pm;
        end else if (h12 >= 5'h12) begin
          nxt[A_HOUR] = {2'b01, pm, 5'h01};
        end else begin
          nxt[A_HOUR] = {2'b01, pm, h12_inc[4:0]};
        end
      end
    end

    if (c_day) begin
      nxt[A_DOW] = (live_o[A_DOW][2:0] >= 3'd7) ? 8'h01 : bcd_inc(live_o[A_DOW]);
      if (live_o[A_DATE] >= last_day(live_o[A_MON], live_o[A_YEAR])) begin
        nxt[A_DATE] = 8'h01;
        c_mon       = 1'b1;
      end else begin
        nxt[A_DATE] = bcd_inc(live_o[A_DATE]);
      end
    end

    if (c_mon) begin
      if (live_o[A_MON] >= 8'h12) begin nxt[A_MON] = 8'h01; c_year = 1'b1; end
      else nxt[A_MON] = bcd_inc(live_o[A_MON]);
    end

    if (c_year) nxt[A_YEAR] = (live_o[A_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(live_o[A_YEAR]);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bcd8_t MASK = wr_mask(AW'(i));
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)         live_o[i] <= 8'h00;
      else if (hit)    live_o[i] <= wr_data_i & MASK;
      else if (step_i) live_o[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snap_i,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        rd_addr_i,
  input  logic [NREG-1:0][7:0] live_i,
  output logic [7:0]           rdata_o
);
  logic [NREG-1:0][7:0] snap;
  logic                 in_map;

  for (genvar i = 0; i < NREG; i++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst)         snap[i] <= 8'h00;
      else if (snap_i) snap[i] <= live_i[i];
    end
  end

  assign in_map = (32'(rd_addr_i) < NREG);

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= 8'h00;
    else if (rd_en_i) begin
      if (!in_map)     rdata_o <= 8'h00;
      else if (snap_i) rdata_o <= live_i[rd_addr_i];
      else             rdata_o <= snap[rd_addr_i];
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          sub_tick,
  input  logic          wr_en,
  input  logic          rd_start,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic                 step;
  logic                 sec_wr;
  logic [NREG-1:0][7:0] live;

  assign sec_wr = wr_en && (addr == A_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst(rst), .en_i(osc_en), .tick_i(sub_tick),
    .restart_i(sec_wr), .step_o(step)
  );

  rtc_counter u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .wr_en_i(wr_en),
    .wr_addr_i(addr), .wr_data_i(wdata), .live_o(live)
  );

  rtc_shadow u_shd (
    .clk(clk), .rst(rst), .snap_i(rd_start), .rd_en_i(rd_en),
    .rd_addr_i(addr), .live_i(live), .rdata_o(rdata)
  );
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [7:0] live_sec
);
  // R3
  rst_clear_chk: assert property (@(posedge clk) rst |=> (rdata == 8'h00 && live_sec == 8'h00));
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !wr_en) |=> $stable(live_sec));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd7) |=> (rdata == 8'h00));
  // R13
  sec_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0) |=> (live_sec == ($past(wdata) & 8'h7F)));
endmodule

bind rtc_bcd_core rtc_bcd_chk chk_i (
  .clk(clk), .rst(rst), .osc_en(osc_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .live_sec(live[0])
);

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0, rst = 1'b1, osc_en = 1'b0, sub_tick = 1'b0;
  logic       wr_en = 1'b0, rd_start = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int   checks = 0, fails = 0, cycles = 0;
  logic pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst(rst), .osc_en(osc_en), .sub_tick(sub_tick), .wr_en(wr_en),
    .rd_start(rd_start), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // monitor: one read result per cycle after an accepted read
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic fresh, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; rd_start = fresh; addr = a;
    @(negedge clk); rd_en = 1'b0; rd_start = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  // index 0 = seconds ... index 6 = year
  task automatic set_time(input logic [6:0][7:0] v);
    for (int i = 6; i >= 0; i--) wr(3'(i), v[i]);
  endtask

  task automatic chk_time(input logic [6:0][7:0] e, input string t);
    for (int i = 0; i < 7; i++) rd(3'(i), 1'b1, e[i], t);
  endtask

  task automatic load_and_step(input logic [6:0][7:0] v, input logic [6:0][7:0] e, input string t);
    osc_en = 1'b0;
    set_time(v);
    osc_en = 1'b1;
    tick(TPS);
    chk_time(e, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_time({8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R3 reset");

    wr(3'd0, 8'hFF); rd(3'd0, 1'b1, 8'h7F, "R2 sec mask");
    wr(3'd3, 8'hFF); rd(3'd3, 1'b1, 8'h07, "R2 dow mask");
    wr(3'd4, 8'hFF); rd(3'd4, 1'b1, 8'h3F, "R2 date mask");
    wr(3'd5, 8'hFF); rd(3'd5, 1'b1, 8'h1F, "R2 month mask");
    wr(3'd7, 8'hAA); rd(3'd7, 1'b1, 8'h00, "R1 unmapped");
    rd(3'd6, 1'b1, 8'h00, "R1 write to 7 ignored");

    // {year, month, date, dow, hour, min, sec}
    load_and_step({8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59},
                  {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00}, "R4/R5/R7/R8 full rollover");
    load_and_step({8'h21, 8'h03, 8'h10, 8'h02, 8'h08, 8'h14, 8'h09},
                  {8'h21, 8'h03, 8'h10, 8'h02, 8'h08, 8'h14, 8'h10}, "R4 bcd 09->10");
    load_and_step({8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59},
                  {8'h00, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00}, "R9 leap 00");
    load_and_step({8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59},
                  {8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00}, "R9 non-leap");
    load_and_step({8'h24, 8'h02, 8'h29, 8'h05, 8'h23, 8'h59, 8'h59},
                  {8'h24, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00}, "R9 leap 29");
    load_and_step({8'h21, 8'h09, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59},
                  {8'h21, 8'h10, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00}, "R8 30-day");
    load_and_step({8'h21, 8'h05, 8'h15, 8'h02, 8'h71, 8'h59, 8'h59},
                  {8'h21, 8'h05, 8'h16, 8'h03, 8'h52, 8'h00, 8'h00}, "R6 11PM->12AM");
    load_and_step({8'h21, 8'h05, 8'h15, 8'h02, 8'h51, 8'h59, 8'h59},
                  {8'h21, 8'h05, 8'h15, 8'h02, 8'h72, 8'h00, 8'h00}, "R6 11AM->12PM");
    load_and_step({8'h21, 8'h05, 8'h15, 8'h02, 8'h52, 8'h59, 8'h59},
                  {8'h21, 8'h05, 8'h15, 8'h02, 8'h41, 8'h00, 8'h00}, "R6 12->01");

    // R10: halted counter ignores ticks
    osc_en = 1'b0;
    wr(3'd0, 8'h30);
    tick(2 * TPS);
    rd(3'd0, 1'b1, 8'h30, "R10 halted");
    osc_en = 1'b1;

    // R11: seconds write restarts the divider
    wr(3'd0, 8'h10);
    tick(TPS - 1);
    wr(3'd0, 8'h20);
    tick(TPS - 1);
    rd(3'd0, 1'b1, 8'h20, "R11 window");
    tick(1);
    rd(3'd0, 1'b1, 8'h21, "R11 step");

    // R12: stale snapshot vs fresh capture
    wr(3'd0, 8'h40);
    rd(3'd0, 1'b1, 8'h40, "R12 capture");
    tick(TPS);
    rd(3'd0, 1'b0, 8'h40, "R12 snapshot");
    rd(3'd0, 1'b1, 8'h41, "R12 fresh");

    // R13: minutes write on the carrying edge
    osc_en = 1'b0;
    wr(3'd2, 8'h10); wr(3'd1, 8'h10); wr(3'd0, 8'h59);
    osc_en = 1'b1;
    tick(TPS - 1);
    @(negedge clk); sub_tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h30;
    @(negedge clk); sub_tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, 1'b1, 8'h00, "R13 sec stepped");
    rd(3'd1, 1'b1, 8'h30, "R13 min written");
    rd(3'd2, 1'b1, 8'h10, "R13 hour unchanged");

    // R13/R11: seconds write on the final tick
    wr(3'd0, 8'h05);
    tick(TPS - 1);
    @(negedge clk); sub_tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h45;
    @(negedge clk); sub_tick = 1'b0; wr_en = 1'b0;
    tick(TPS - 1);
    rd(3'd0, 1'b1, 8'h45, "R13 sec write wins");
    tick(1);
    rd(3'd0, 1'b1, 8'h46, "R11 full second after write");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule